// File: doc/BRIEF.md
# Hard-Wired Program Processor Core

A small 16-bit processor core that has no instruction store. The program counter indexes a combinational case table, and each entry of that table directly supplies the data-path controls: source and destination register numbers, write enable, ALU operation and jump target. The program is therefore fixed when the core is built. Operands live only in an internal register file. The outside world connects through one 16-bit input port, which an input instruction copies into a register, and one 16-bit output port, which an output instruction loads and which then holds its value.

Instructions flow through three stages. In decode, the PC selects a table entry, whose controls include the register read addresses. In execute, the operands are read, with forwarding from the instruction one ahead, and the ALU result and write are prepared. In writeback, the register file is written. One instruction retires per clock. The only exception is a taken jump, which squashes the single instruction behind it.

The built-in program reads the input port, runs a chain of back-to-back dependent ALU operations, and emits six results per pass. It jumps over a region whose first entry would otherwise emit a value, then falls through the tail of the 64-entry table and wraps to entry 0.

Top module: `pcprog_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0, invalidates both pipeline stages so that no register write occurs, clears `out_data` to 0 and holds `out_strobe` low. After release, the first output update of the built-in program appears 7 clocks later.
- R2: Without a taken jump, the PC advances by one every clock. After entry 63 it wraps to 0, so the gap from the last output of a pass to the first output of the next pass is 26 clocks.
- R3: The ALU performs add, subtract (first operand minus second), AND, OR and copy, all modulo 2^16. For input x, a pass emits these six values in this order: o1 = (x-3x) & 3x; o2 = o1 | x; o3 = 2·o2; o4 = 2x; o5 = o4 + o3; o6 = o5 - x.
- R4: The input instruction copies `in_data` into a register while it is in the execute stage.
- R5: An output instruction loads its source register into `out_data` and pulses `out_strobe` high for that clock. Otherwise `out_data` holds its value.
- R6: An instruction that reads the register written by the instruction directly before it receives the new value, not the stale register-file contents.
- R7: A jump taken in execute loads its constant target into the PC and squashes the one instruction behind it. That instruction is an output of x and must never appear, and the gap from o4 to o5 is 4 clocks.
- R8: The core completes one instruction per clock. Output gaps inside a pass are 3, 2, 3 and 2 clocks for o1→o2, o2→o3, o3→o4 and o5→o6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Input port, read by the input instruction |
| out_data | output | 16 | Output port, held between updates |
| out_strobe | output | 1 | High for the clock after an output update |

## Verification
The program is run with hundreds of input words: zero, one, all ones, the sign bit alone, the largest positive value, alternating bit patterns, and a spread of scrambled values. A stale operand would give a result from the previous pass or a zero, and a missing carry or borrow shows up on the extreme words. The AND/OR mix separates a wrong ALU operation from a wrong operand. Clock gaps between updates tell a missing squash, a wrong jump target or a broken wrap apart from a value error. A reset in mid-run checks that the output clears and that the program restarts with the expected first-output latency.

// File: rtl/pcprog_core.sv
module pcprog_core #(
  parameter int DW   = 16,
  parameter int PCW  = 6,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_strobe
);
  localparam int RAW = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_MOV, OP_IN, OP_OUT, OP_JMP
  } op_t;

  logic [PCW-1:0] pc;
  op_t            d_op;
  logic [RAW-1:0] d_ra, d_rb, d_wa;
  logic [PCW-1:0] d_tgt;

  logic           e_valid;
  op_t            e_op;
  logic [RAW-1:0] e_ra, e_rb, e_wa;
  logic [PCW-1:0] e_tgt;

  logic           wb_wr;
  logic [RAW-1:0] wb_wa;
  logic [DW-1:0]  wb_data;

  logic [DW-1:0]  rf [NREG];
  logic [DW-1:0]  opa, opb, alu;
  logic           e_wr, jmp_take;

  // Program table: controls are a pure function of the PC.
  always_comb begin
    d_op  = OP_NOP;
    d_ra  = '0;
    d_rb  = '0;
    d_wa  = '0;
    d_tgt = '0;
    case (pc)
      PCW'(0):  begin d_op = OP_IN;  d_wa = RAW'(1); end
      PCW'(1):  begin d_op = OP_ADD; d_wa = RAW'(2); d_ra = RAW'(1); d_rb = RAW'(1); end
      PCW'(2):  begin d_op = OP_ADD; d_wa = RAW'(2); d_ra = RAW'(2); d_rb = RAW'(1); end
      PCW'(3):  begin d_op = OP_SUB; d_wa = RAW'(3); d_ra = RAW'(1); d_rb = RAW'(2); end
      PCW'(4):  begin d_op = OP_AND; d_wa = RAW'(4); d_ra = RAW'(3); d_rb = RAW'(2); end
      PCW'(5):  begin d_op = OP_OUT; d_ra = RAW'(4); end
      PCW'(6):  begin d_op = OP_OR;  d_wa = RAW'(5); d_ra = RAW'(4); d_rb = RAW'(1); end
      PCW'(7):  begin d_op = OP_MOV; d_wa = RAW'(6); d_ra = RAW'(5); end
      PCW'(8):  begin d_op = OP_OUT; d_ra = RAW'(6); end
      PCW'(9):  begin d_op = OP_ADD; d_wa = RAW'(6); d_ra = RAW'(6); d_rb = RAW'(6); end
      PCW'(10): begin d_op = OP_OUT; d_ra = RAW'(6); end
      PCW'(12): begin d_op = OP_SUB; d_wa = RAW'(2); d_ra = RAW'(2); d_rb = RAW'(1); end
      PCW'(13): begin d_op = OP_OUT; d_ra = RAW'(2); end
      PCW'(14): begin d_op = OP_JMP; d_tgt = PCW'(40); end
      PCW'(15): begin d_op = OP_OUT; d_ra = RAW'(1); end
      PCW'(16): begin d_op = OP_OUT; d_ra = RAW'(3); end
      PCW'(40): begin d_op = OP_ADD; d_wa = RAW'(7); d_ra = RAW'(2); d_rb = RAW'(6); end
      PCW'(41): begin d_op = OP_OUT; d_ra = RAW'(7); end
      PCW'(42): begin d_op = OP_SUB; d_wa = RAW'(0); d_ra = RAW'(7); d_rb = RAW'(1); end
      PCW'(43): begin d_op = OP_OUT; d_ra = RAW'(0); end
      default: ;
    endcase
  end

  assign jmp_take = e_valid && (e_op == OP_JMP);
  assign e_wr = e_valid && (e_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_MOV, OP_IN});

  // PC sequencer and decode-to-execute stage (R2, R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      e_valid <= 1'b0;
      e_op    <= OP_NOP;
      e_ra    <= '0;
      e_rb    <= '0;
      e_wa    <= '0;
      e_tgt   <= '0;
    end else begin
      pc      <= jmp_take ? e_tgt : pc + 1'b1;
      e_valid <= !jmp_take;
      e_op    <= d_op;
      e_ra    <= d_ra;
      e_rb    <= d_rb;
      e_wa    <= d_wa;
      e_tgt   <= d_tgt;
    end
  end

  // Operand read with bypass from the instruction in writeback (R6)
  assign opa = (wb_wr && wb_wa == e_ra) ? wb_data : rf[e_ra];
  assign opb = (wb_wr && wb_wa == e_rb) ? wb_data : rf[e_rb];

  always_comb begin
    case (e_op)
      OP_ADD:  alu = opa + opb;
      OP_SUB:  alu = opa - opb;
      OP_AND:  alu = opa & opb;
      OP_OR:   alu = opa | opb;
      OP_IN:   alu = in_data;
      default: alu = opa;
    endcase
  end

  // Execute-to-writeback stage and output port (R1, R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_wr      <= 1'b0;
      wb_wa      <= '0;
      wb_data    <= '0;
      out_data   <= '0;
      out_strobe <= 1'b0;
    end else begin
      wb_wr      <= e_wr;
      wb_wa      <= e_wa;
      wb_data    <= alu;
      out_strobe <= e_valid && (e_op == OP_OUT);
      if (e_valid && e_op == OP_OUT) out_data <= opa;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_wr) rf[wb_wa] <= wb_data;
  end
endmodule

module pcprog_core_chk #(
  parameter int DW  = 16,
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc,
  input logic [PCW-1:0] e_tgt,
  input logic           e_valid,
  input logic           wb_wr,
  input logic           jmp_take,
  input logic [DW-1:0]  out_data,
  input logic           out_strobe
);
  logic       live;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b1;
      age  <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst || live !== 1'b1)
    age == 2'd0 |-> pc == '0 && !e_valid && !wb_wr && out_data == '0 && !out_strobe);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst || live !== 1'b1)
    age != 2'd0 && !$past(jmp_take) |-> pc == PCW'($past(pc) + 1'b1));

  a_r7_jump_squash: assert property (@(posedge clk) disable iff (rst || live !== 1'b1)
    age != 2'd0 && $past(jmp_take) |-> pc == $past(e_tgt) && !e_valid);

  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst || live !== 1'b1)
    age != 2'd0 && !out_strobe |-> $stable(out_data));
endmodule

bind pcprog_core pcprog_core_chk #(.DW(DW), .PCW(PCW)) chk_i (
  .clk(clk), .rst(rst), .pc(pc), .e_tgt(e_tgt), .e_valid(e_valid),
  .wb_wr(wb_wr), .jmp_take(jmp_take), .out_data(out_data), .out_strobe(out_strobe)
);

// File: tb/pcprog_core_tb_top.sv
`timescale 1ns/1ps
module pcprog_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_data = '0;
  logic [15:0] out_data;
  logic        out_strobe;

  int n_chk = 0, n_fail = 0, ncyc = 0, last_t = 0;
  logic [15:0] held = '0;
  bit hold_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcprog_core dut_i (
    .clk(clk), .rst(rst), .in_data(in_data),
    .out_data(out_data), .out_strobe(out_strobe)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ncyc++;
    if (!out_strobe && out_data !== held) hold_bad = 1;
    if (out_strobe) held = out_data;
  endtask

  task automatic wait_strobe(output bit got);
    got = 0;
    for (int i = 0; i < 80; i++) begin
      step();
      if (out_strobe) begin
        got = 1;
        break;
      end
    end
  endtask

  function automatic logic [15:0] pat(input int p);
    case (p)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hffff;
      3: return 16'h8000;
      4: return 16'h7fff;
      5: return 16'haaaa;
      6: return 16'h5555;
      default: return 16'(p * 40503) ^ 16'(p << 3);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] x, t2, t3, m2;
    logic [15:0] exp_v [6];
    int gaps [6];
    string tags [6];
    bit got, first;

    repeat (3) @(negedge clk);
    check(out_data == 16'h0 && !out_strobe, "R1 reset output", out_data, 16'h0);
    in_data = pat(0);
    rst = 1'b0;
    ncyc = 0; last_t = 0; first = 1;

    for (int p = 0; p < 300; p++) begin
      x = pat(p);
      in_data = x;
      t2 = x + x;
      t3 = t2 + x;
      m2 = x - t3;
      exp_v[0] = m2 & t3;
      exp_v[1] = exp_v[0] | x;
      exp_v[2] = exp_v[1] + exp_v[1];
      exp_v[3] = t3 - x;
      exp_v[4] = exp_v[3] + exp_v[2];
      exp_v[5] = exp_v[4] - x;
      gaps[0] = first ? 7 : 26; tags[0] = first ? "R1 first-output latency" : "R2 wrap gap";
      gaps[1] = 3; tags[1] = "R8 gap o1-o2";
      gaps[2] = 2; tags[2] = "R8 gap o2-o3";
      gaps[3] = 3; tags[3] = "R8 gap o3-o4";
      gaps[4] = 4; tags[4] = "R7 jump gap o4-o5";
      gaps[5] = 2; tags[5] = "R8 gap o5-o6";
      hold_bad = 0;
      for (int k = 0; k < 6; k++) begin
        wait_strobe(got);
        if (!got) begin
          n_fail++;
          $display("FAIL R5 no output update actual=none expected=%h", exp_v[k]);
          done = 1;
          break;
        end
        // R3 R4 R6 R7: value sequence (a squashed-output leak gives x in slot o5)
        check(out_data == exp_v[k], $sformatf("R3 R6 value o%0d x=%h", k + 1, x), out_data, exp_v[k]);
        check(ncyc - last_t == gaps[k], tags[k], 16'(ncyc - last_t), 16'(gaps[k]));
        last_t = ncyc;
      end
      if (done) break;
      check(!hold_bad, "R5 output held between updates", 16'(hold_bad), 16'h0);
      first = 0;

      if (p == 100) begin
        rst = 1'b1;
        step();
        step();
        check(out_data == 16'h0 && !out_strobe, "R1 mid-run reset clears output", out_data, 16'h0);
        in_data = pat(101);
        rst = 1'b0;
        ncyc = 0; last_t = 0; held = '0; first = 1;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule